// File: doc/BRIEF.md
# Collision-Free Two-Write Parity Memory

This block is a small on-chip memory that takes two independent writes and one read in every clock cycle. Nothing stalls and nothing arbitrates. Storage is split into two data banks and one shared reference bank, each of `DEPTH` words. The logical address space holds `2*DEPTH` words. The most significant address bit picks the bank, and the remaining bits pick the offset inside it.

Each bank word is stored encoded: it is the logical value XORed with the reference word at the same offset. A read decodes it as `bank[offset] ^ ref[offset]`. Two writes that land in different banks each update only their own bank.

Two writes can also fall in the same bank at different offsets. In that case the first port's word goes straight into that bank. The second port's word is absorbed another way: the reference word at its offset is rewritten, and the other bank's word at that offset is re-encoded. This keeps every logical value intact. The memory suits datapaths that must retire two stores per cycle whatever address pattern they follow.

Top module: `xdw_mem`

## Requirements
- R1: After a synchronous active-low reset, `rd_data` is zero and every one of the `2*DEPTH` locations reads as zero.
- R2: `rd_data` shows the word at the `rd_addr` presented one clock earlier. It reflects the contents before any write accepted in that same cycle.
- R3: Address bit `[log2(DEPTH)]` selects the bank (0 or 1) and the lower bits select the offset. All `2*DEPTH` locations are independent, so a write never alters a location other than the one it targets.
- R4: A port-0 write alone (`wr0_en`=1, `wr1_en`=0) stores `wr0_data` at `wr0_addr`.
- R5: A port-1 write alone stores `wr1_data` at `wr1_addr`.
- R6: Two same-cycle writes to different banks both store, including when they use the same offset.
- R7: Two same-cycle writes to bank 0 at different offsets both store. The bank-1 location at port 1's offset keeps its value.
- R8: Two same-cycle writes to bank 1 at different offsets both store. The bank-0 location at port 1's offset keeps its value.
- R9: Two same-cycle writes to the same full address leave `wr1_data` stored there.
- R10: Write pairs are accepted on every cycle, back to back, with no stall. The reference bank is rewritten only in the cycle of a same-bank, different-offset pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr0_en | input | 1 | Port-0 write enable |
| wr0_addr | input | log2(DEPTH)+1 | Port-0 address, MSB = bank |
| wr0_data | input | DATA_W | Port-0 write data |
| wr1_en | input | 1 | Port-1 write enable |
| wr1_addr | input | log2(DEPTH)+1 | Port-1 address, MSB = bank |
| wr1_data | input | DATA_W | Port-1 write data |
| rd_addr | input | log2(DEPTH)+1 | Read address |
| rd_data | output | DATA_W | Decoded read word, one cycle after `rd_addr` |

## Verification
Some properties are checked on every cycle by the assertions:
- the reference bank is written exactly when a same-bank pair at different offsets arrives;
- such a pair drives a write into both data banks;
- a same-address pair produces a single bank write and no reference write;
- a word written by either port reads back two cycles later through the read port.

The assertions cannot show that the re-encoded word in the other bank still decodes to its earlier value, or that other locations are untouched. Those come from the bench. It sweeps every address pair and enable mix over a small memory, compares the whole address space against a flat model after each pair, and then runs long back-to-back bursts that force frequent collisions.

// File: rtl/xdw_pkg.sv
// Shared types for the two-write parity memory.
// Assumes nothing beyond standard SystemVerilog.
package xdw_pkg;

    // Which request a data bank's single write port serves in a cycle
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_P0    = 2'd1,
        SRC_P1    = 2'd2,
        SRC_REENC = 2'd3
    } wsrc_e;

endpackage

// File: rtl/xdw_store.sv
// Flop-based word array with one write port and NRD asynchronous read ports.
// Assumes DEPTH >= 2; contents clear to zero on synchronous active-low reset.
module xdw_store #(
    parameter int W     = 32,
    parameter int DEPTH = 64,
    parameter int NRD   = 2,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr [NRD],
    output logic [W-1:0]  rdata [NRD]
);

    logic [W-1:0] mem [DEPTH];

    // Storage update: clear on reset, otherwise one optional write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < DEPTH; n++) begin
                mem[n] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read ports: plain combinational lookups
    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rdata[r] = mem[raddr[r]];
    end

endmodule

// File: rtl/xdw_route.sv
// Write router: turns two write requests into one write per data bank plus
// an optional reference-bank write. Same-bank pairs at different offsets
// re-encode port 1 through the reference word and the other bank.
// Assumes the read values it receives are the stored words before this
// cycle's writes.
module xdw_route
    import xdw_pkg::*;
#(
    parameter int W  = 32,
    parameter int OW = 6
) (
    input  logic          we0,
    input  logic          bank0,
    input  logic [OW-1:0] off0,
    input  logic [W-1:0]  d0,
    input  logic          we1,
    input  logic          bank1,
    input  logic [OW-1:0] off1,
    input  logic [W-1:0]  d1,
    input  logic [W-1:0]  bank_at_j [2],
    input  logic [W-1:0]  ref_at_i,
    input  logic [W-1:0]  ref_at_j,
    output logic [1:0]    bk_we,
    output logic [OW-1:0] bk_addr [2],
    output logic [W-1:0]  bk_data [2],
    output logic          ref_we,
    output logic [OW-1:0] ref_addr,
    output logic [W-1:0]  ref_data
);

    logic         same_bank;
    logic         coll;
    logic         same_loc;
    logic         p0_go;
    logic [W-1:0] new_ref;

    // Classify the request pair and compute the rewritten reference word
    always_comb begin
        same_bank = we0 && we1 && (bank0 == bank1);
        coll      = same_bank && (off0 != off1);
        same_loc  = same_bank && (off0 == off1);
        p0_go     = we0 && !same_loc;
        new_ref   = d1 ^ bank_at_j[bank1];
    end

    // Reference bank is written only to absorb a colliding port-1 write
    always_comb begin
        ref_we   = coll;
        ref_addr = off1;
        ref_data = new_ref;
    end

    for (genvar k = 0; k < 2; k++) begin : g_bank
        localparam logic KB = 1'(k);
        wsrc_e src;

        // Choose what this bank's single write port serves this cycle
        always_comb begin
            if (p0_go && bank0 == KB) begin
                src = SRC_P0;
            end else if (we1 && bank1 == KB && !coll) begin
                src = SRC_P1;
            end else if (coll && bank1 != KB) begin
                src = SRC_REENC;
            end else begin
                src = SRC_NONE;
            end
        end

        // Encode the chosen word against the proper reference word
        always_comb begin
            bk_we[k]   = 1'b0;
            bk_addr[k] = off1;
            bk_data[k] = '0;
            case (src)
                SRC_P0: begin
                    bk_we[k]   = 1'b1;
                    bk_addr[k] = off0;
                    bk_data[k] = d0 ^ ref_at_i;
                end
                SRC_P1: begin
                    bk_we[k]   = 1'b1;
                    bk_data[k] = d1 ^ ref_at_j;
                end
                SRC_REENC: begin
                    bk_we[k]   = 1'b1;
                    bk_data[k] = new_ref ^ (bank_at_j[k] ^ ref_at_j);
                end
                default: begin
                    bk_we[k] = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/xdw_mem.sv
// Two-write, one-read memory built from two XOR-encoded data banks and a
// shared reference bank. Address MSB selects the bank. The read has one
// cycle of latency and returns contents from before same-cycle writes.
// Assumes DEPTH is a power of two and at least 2.
module xdw_mem #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr0_en,
    input  logic [$clog2(DEPTH):0]   wr0_addr,
    input  logic [DATA_W-1:0]        wr0_data,
    input  logic                     wr1_en,
    input  logic [$clog2(DEPTH):0]   wr1_addr,
    input  logic [DATA_W-1:0]        wr1_data,
    input  logic [$clog2(DEPTH):0]   rd_addr,
    output logic [DATA_W-1:0]        rd_data
);

    localparam int OW = $clog2(DEPTH);

    logic [OW-1:0]     off0, off1, rd_off;
    logic              bank0, bank1, rd_bank;

    logic [1:0]        bk_we;
    logic [OW-1:0]     bk_addr [2];
    logic [DATA_W-1:0] bk_data [2];
    logic              ref_we;
    logic [OW-1:0]     ref_addr;
    logic [DATA_W-1:0] ref_data;

    logic [DATA_W-1:0] bank_at_j [2];
    logic [DATA_W-1:0] bank_at_rd [2];
    logic [DATA_W-1:0] ref_rd [3];
    logic [OW-1:0]     ref_raddr [3];
    logic [DATA_W-1:0] rd_word;

    // Split addresses into bank select and offset
    always_comb begin
        bank0   = wr0_addr[OW];
        off0    = wr0_addr[OW-1:0];
        bank1   = wr1_addr[OW];
        off1    = wr1_addr[OW-1:0];
        rd_bank = rd_addr[OW];
        rd_off  = rd_addr[OW-1:0];
    end

    for (genvar k = 0; k < 2; k++) begin : g_data
        logic [OW-1:0]     raddr [2];
        logic [DATA_W-1:0] rdata [2];

        // Bank reads: port-1 offset for re-encoding, read offset for output
        always_comb begin
            raddr[0]      = off1;
            raddr[1]      = rd_off;
            bank_at_j[k]  = rdata[0];
            bank_at_rd[k] = rdata[1];
        end

        xdw_store #(.W(DATA_W), .DEPTH(DEPTH), .NRD(2)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bk_we[k]),
            .waddr (bk_addr[k]),
            .wdata (bk_data[k]),
            .raddr (raddr),
            .rdata (rdata)
        );
    end

    // Reference reads: both write offsets and the read offset
    always_comb begin
        ref_raddr[0] = off0;
        ref_raddr[1] = off1;
        ref_raddr[2] = rd_off;
    end

    xdw_store #(.W(DATA_W), .DEPTH(DEPTH), .NRD(3)) u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ref_we),
        .waddr (ref_addr),
        .wdata (ref_data),
        .raddr (ref_raddr),
        .rdata (ref_rd)
    );

    xdw_route #(.W(DATA_W), .OW(OW)) u_route (
        .we0       (wr0_en),
        .bank0     (bank0),
        .off0      (off0),
        .d0        (wr0_data),
        .we1       (wr1_en),
        .bank1     (bank1),
        .off1      (off1),
        .d1        (wr1_data),
        .bank_at_j (bank_at_j),
        .ref_at_i  (ref_rd[0]),
        .ref_at_j  (ref_rd[1]),
        .bk_we     (bk_we),
        .bk_addr   (bk_addr),
        .bk_data   (bk_data),
        .ref_we    (ref_we),
        .ref_addr  (ref_addr),
        .ref_data  (ref_data)
    );

    // Decode the addressed word against its reference word
    always_comb begin
        rd_word = bank_at_rd[rd_bank] ^ ref_rd[2];
    end

    // Read output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= rd_word;
        end
    end

endmodule

// File: rtl/xdw_mem_chk.sv
// Assertion checker for xdw_mem, attached by bind. Watches the ports and
// the router-to-storage write controls.
module xdw_mem_chk #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64,
    localparam int OW    = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr0_en,
    input logic [OW:0]       wr0_addr,
    input logic [DATA_W-1:0] wr0_data,
    input logic              wr1_en,
    input logic [OW:0]       wr1_addr,
    input logic [DATA_W-1:0] wr1_data,
    input logic [OW:0]       rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic [1:0]        bk_we,
    input logic              ref_we
);

    logic [1:0] run_cnt;

    // Counts clean cycles after reset so two-deep history is valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (run_cnt != 2'd3) begin
            run_cnt <= run_cnt + 2'd1;
        end
    end

    // R10: the reference bank is written only by a same-bank collision
    a_r10_ref_only_on_collision: assert property (@(posedge clk) disable iff (!rst_n)
        ref_we |-> (wr0_en && wr1_en && wr0_addr[OW] == wr1_addr[OW]
                    && wr0_addr[OW-1:0] != wr1_addr[OW-1:0]));

    // R10: every same-bank collision rewrites the reference bank
    a_r10_collision_writes_ref: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0_en && wr1_en && wr0_addr[OW] == wr1_addr[OW]
         && wr0_addr[OW-1:0] != wr1_addr[OW-1:0]) |-> ref_we);

    // R7 / R8: a collision drives a write into both data banks
    a_r7_collision_both_banks: assert property (@(posedge clk) disable iff (!rst_n)
        ref_we |-> (bk_we == 2'b11));

    // R9: a same-address pair makes exactly one bank write
    a_r9_same_addr_single: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0_en && wr1_en && wr0_addr == wr1_addr)
            |-> ($countones(bk_we) == 1 && !ref_we));

    // R5: a port-1 word reads back two cycles later
    a_r5_port1_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt == 2'd3 && $past(wr1_en, 2) && $past(rd_addr) == $past(wr1_addr, 2))
            |-> rd_data == $past(wr1_data, 2));

    // R4: a port-0 word not overridden by port 1 reads back two cycles later
    a_r4_port0_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt == 2'd3 && $past(wr0_en, 2) && $past(rd_addr) == $past(wr0_addr, 2)
         && !($past(wr1_en, 2) && $past(wr1_addr, 2) == $past(wr0_addr, 2)))
            |-> rd_data == $past(wr0_data, 2));

endmodule

bind xdw_mem xdw_mem_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_xdw_mem_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr0_en   (wr0_en),
    .wr0_addr (wr0_addr),
    .wr0_data (wr0_data),
    .wr1_en   (wr1_en),
    .wr1_addr (wr1_addr),
    .wr1_data (wr1_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .bk_we    (bk_we),
    .ref_we   (ref_we)
);

// File: tb/test_xdw_mem.sv
// Bench for xdw_mem: exhaustive pair sweep on a tiny memory plus
// collision-heavy back-to-back bursts, all checked against a flat model.
module test_xdw_mem;

    localparam int W     = 8;
    localparam int DEPTH = 4;
    localparam int OW    = $clog2(DEPTH);
    localparam int NLOC  = 2 * DEPTH;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr0_en = 1'b0, wr1_en = 1'b0;
    logic [OW:0]   wr0_addr = '0, wr1_addr = '0, rd_addr = '0;
    logic [W-1:0]  wr0_data = '0, wr1_data = '0;
    logic [W-1:0]  rd_data;

    logic [W-1:0]  model [NLOC];
    int            n_chk = 0;
    int            n_bad = 0;
    bit            finished = 1'b0;

    always #5 clk = ~clk;

    xdw_mem #(.DATA_W(W), .DEPTH(DEPTH)) i_xdw_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr0_en   (wr0_en),
        .wr0_addr (wr0_addr),
        .wr0_data (wr0_data),
        .wr1_en   (wr1_en),
        .wr1_addr (wr1_addr),
        .wr1_data (wr1_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    // Apply one write pair for one cycle and update the flat model
    task automatic put(input bit e0, input int a0, input logic [W-1:0] d0,
                       input bit e1, input int a1, input logic [W-1:0] d1);
        @(negedge clk);
        wr0_en = e0; wr0_addr = (OW+1)'(a0); wr0_data = d0;
        wr1_en = e1; wr1_addr = (OW+1)'(a1); wr1_data = d1;
        if (e0) model[a0] = d0;
        if (e1) model[a1] = d1;
    endtask

    task automatic idle();
        @(negedge clk);
        wr0_en = 1'b0; wr1_en = 1'b0;
    endtask

    // Read one location and compare with the model
    task automatic read_chk(input int a, input string tag);
        @(negedge clk);
        wr0_en = 1'b0; wr1_en = 1'b0;
        rd_addr = (OW+1)'(a);
        @(negedge clk);
        check($sformatf("%s addr %0d", tag, a), rd_data, model[a]);
    endtask

    function automatic string pair_tag(int en, int a0, int a1, int loc);
        bit b0 = a0[OW];
        bit b1 = a1[OW];
        int other = ((b1 ? 0 : 1) << OW) | (a1 % DEPTH);
        if (en == 1) return (loc == a0) ? "R4" : "R3";
        if (en == 2) return (loc == a1) ? "R5" : "R3";
        if (a0 == a1) return (loc == a1) ? "R9" : "R3";
        if (b0 != b1) return (loc == a0 || loc == a1) ? "R6" : "R3";
        if (loc == a0 || loc == a1 || loc == other) return b0 ? "R8" : "R7";
        return "R3";
    endfunction

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < NLOC; a++) model[a] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: output and every location read zero after reset
        check("R1 rd_data after reset", rd_data, '0);
        for (int a = 0; a < NLOC; a++) read_chk(a, "R1");

        // R2: a read in the write cycle returns the old word, then the new
        @(negedge clk);
        model[5] = 8'h3C;
        wr0_en = 1'b1; wr0_addr = 3'd5; wr0_data = 8'h3C; rd_addr = 3'd5;
        @(negedge clk);
        wr0_en = 1'b0;
        check("R2 read-before-write", rd_data, 8'h00);
        @(negedge clk);
        check("R2 read after write", rd_data, 8'h3C);

        // Exhaustive pair sweep: enable mix x both addresses, full readback
        for (int en = 1; en <= 3; en++) begin
            for (int a0 = 0; a0 < NLOC; a0++) begin
                for (int a1 = 0; a1 < NLOC; a1++) begin
                    int k = (en * 64) + (a0 * 8) + a1;
                    put(en[0], a0, W'(k * 7 + 13), en[1], a1, W'(k * 11 + 90));
                    idle();
                    for (int loc = 0; loc < NLOC; loc++)
                        read_chk(loc, pair_tag(en, a0, a1, loc));
                end
            end
        end

        // R10: back-to-back bursts with frequent same-bank collisions
        for (int burst = 0; burst < 60; burst++) begin
            for (int s = 0; s < 50; s++) begin
                int a0 = int'($urandom_range(NLOC - 1));
                int a1 = int'($urandom_range(NLOC - 1));
                if ($urandom_range(1) == 1) a1 = (a0 & DEPTH) | (a1 % DEPTH);
                put(1'b1, a0, W'($urandom), ($urandom_range(7) != 0), a1, W'($urandom));
            end
            idle();
            for (int loc = 0; loc < NLOC; loc++) read_chk(loc, "R10");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule